// File: doc/BRIEF.md
# SDRAM Command Front End with Bank State and Mode Register

This block sits at the pin boundary of a synchronous DRAM model. On every rising clock edge it samples the chip select, the three command strobes, the clock enable, the bank select and the address bus. It turns these into a one-hot command strobe vector and presents it one cycle later, together with the target bank, the row or column address and the auto-precharge flag. The array, timing checks and data path behind it consume these outputs.

Alongside the decode, the block keeps an idle or active flag for every bank. It also holds the operating-mode register: burst length code, burst ordering, CAS latency and write-burst mode. A mode load that carries an unsupported CAS latency or a nonzero test field is refused and flagged. A read or write aimed at an idle bank is also flagged.

Top module: `sdram_cmd_front`

## Requirements
- R1: With cs_n low and cke high, the {ras_n,cas_n,we_n} pattern selects one strobe bit: 111 NOP bit0, 011 activate bit1, 101 read bit2, 100 write bit3, 010 with addr[10] low single-bank precharge bit4, 010 with addr[10] high all-bank precharge bit5, 001 refresh bit6, 000 mode load bit7, 110 burst stop bit8. At most one bit is ever set.
- R2: When cs_n is high or cke is low, no strobe is raised, no output address or bank is given, and neither the bank flags nor the mode register change.
- R3: Activate sets the flag of bank ba; cmd_bank shows ba and cmd_addr shows the full row address.
- R4: Read and write give cmd_bank = ba, cmd_addr = addr[8:0] zero-extended, and cmd_autopre = addr[10]. When addr[10] is high the addressed bank flag is cleared.
- R5: Single-bank precharge clears only bank ba. All-bank precharge clears every bank flag, whatever the flags were before.
- R6: A mode load with a legal value updates burst length code from addr[2:0], burst type from addr[3], CAS latency from addr[6:4] and write mode from addr[9].
- R7: A mode load whose addr[6:4] is neither 2 nor 3, or whose addr[8:7] is nonzero, leaves the mode register unchanged and raises mode_err for one cycle; the mode-load strobe still fires.
- R8: A read or write to a bank whose flag is clear raises access_err for one cycle. The strobe still fires.
- R9: After reset all strobes, errors, bank flags and outputs are zero, and the mode register holds burst code 0, burst type 0, CAS latency 3 and write mode 0.
- R10: Every output reflects the inputs sampled at the previous rising edge, and a strobe lasts exactly one cycle per sampled command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; low masks the command |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column or mode value |
| cmd_strobe | output | 9 | One-hot decoded command |
| cmd_bank | output | 2 | Bank of activate, read, write or single precharge |
| cmd_addr | output | 13 | Row for activate, column for read/write |
| cmd_autopre | output | 1 | Auto-precharge request of read/write |
| bank_active | output | 4 | Per-bank active flag |
| mr_burst_len | output | 3 | Burst length code |
| mr_burst_type | output | 1 | Burst ordering: 0 sequential, 1 interleaved |
| mr_cas_lat | output | 3 | CAS latency |
| mr_wr_single | output | 1 | Write burst mode bit |
| mode_err | output | 1 | Refused mode load pulse |
| access_err | output | 1 | Access to idle bank pulse |

## Verification
The checker watches on every cycle that the strobe is one-hot or empty, and that a masked or deselected cycle yields nothing. It also checks that activate leaves its bank flagged, that all-bank precharge empties the flags, and that the CAS latency always stays legal. It confirms that a refused mode load holds the register and that an access error only comes with a read or write. Exact address and column extraction, auto-precharge clearing of a single bank, and the sequence of bank flags across several commands are shown only by the bench's scenarios. So are the precise field mapping of a mode load and the reset values.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
   localparam int CMD_N = 9;
   localparam int S_NOP    = 0;
   localparam int S_ACT    = 1;
   localparam int S_RD     = 2;
   localparam int S_WR     = 3;
   localparam int S_PRE    = 4;
   localparam int S_PREALL = 5;
   localparam int S_REF    = 6;
   localparam int S_MRS    = 7;
   localparam int S_BST    = 8;

   typedef struct packed {
      logic [2:0] burst_len;
      logic       burst_type;
      logic [2:0] cas_lat;
      logic       wr_single;
   } mode_t;
endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
   import sdcf_pkg::*;
(
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             cke,
   input  logic             all_sel,
   output logic [CMD_N-1:0] strobe
);
   always_comb begin
      strobe = '0;
      if (!cs_n && cke) begin
         unique case ({ras_n, cas_n, we_n})
            3'b111: strobe[S_NOP] = 1'b1;
            3'b011: strobe[S_ACT] = 1'b1;
            3'b101: strobe[S_RD]  = 1'b1;
            3'b100: strobe[S_WR]  = 1'b1;
            3'b010: begin
               if (all_sel) strobe[S_PREALL] = 1'b1;
               else         strobe[S_PRE]    = 1'b1;
            end
            3'b001: strobe[S_REF] = 1'b1;
            3'b000: strobe[S_MRS] = 1'b1;
            3'b110: strobe[S_BST] = 1'b1;
            default: strobe = '0;
         endcase
      end
   end
endmodule

// File: rtl/sdcf_banks.sv
module sdcf_banks
   import sdcf_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CMD_N-1:0]     strobe,
   input  logic [BA_W-1:0]      ba,
   input  logic                 ap,
   output logic [NUM_BANKS-1:0] active
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit, set_b, clr_b;
      assign hit   = (ba == BA_W'(b));
      assign set_b = strobe[S_ACT] && hit;
      assign clr_b = strobe[S_PREALL]
                   || (strobe[S_PRE] && hit)
                   || ((strobe[S_RD] || strobe[S_WR]) && ap && hit);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     active[b] <= 1'b0;
         else if (set_b) active[b] <= 1'b1;
         else if (clr_b) active[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/sdcf_mode.sv
module sdcf_mode
   import sdcf_pkg::*;
#(
   parameter int         ADDR_W   = 13,
   parameter logic [2:0] RESET_CL = 3'd3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] value,
   output mode_t             mode,
   output logic              err
);
   logic [2:0] cl_in;
   logic       legal;

   if (ADDR_W < 10) begin : g_chk_w
      $error("mode register needs at least ten address bits");
   end
   if (RESET_CL != 3'd2 && RESET_CL != 3'd3) begin : g_chk_cl
      $error("reset CAS latency must be 2 or 3");
   end

   assign cl_in = value[6:4];
   assign legal = ((cl_in == 3'd2) || (cl_in == 3'd3)) && (value[8:7] == 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '{burst_len: 3'd0, burst_type: 1'b0, cas_lat: RESET_CL, wr_single: 1'b0};
         err  <= 1'b0;
      end else begin
         err <= load && !legal;
         if (load && legal) begin
            mode.burst_len  <= value[2:0];
            mode.burst_type <= value[3];
            mode.cas_lat    <= cl_in;
            mode.wr_single  <= value[9];
         end
      end
   end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdcf_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int COL_W     = 9,
   parameter int AP_BIT    = 10,
   localparam int BA_W     = $clog2(NUM_BANKS)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 cke,
   input  logic [BA_W-1:0]      ba,
   input  logic [ROW_W-1:0]     addr,
   output logic [CMD_N-1:0]     cmd_strobe,
   output logic [BA_W-1:0]      cmd_bank,
   output logic [ROW_W-1:0]     cmd_addr,
   output logic                 cmd_autopre,
   output logic [NUM_BANKS-1:0] bank_active,
   output logic [2:0]           mr_burst_len,
   output logic                 mr_burst_type,
   output logic [2:0]           mr_cas_lat,
   output logic                 mr_wr_single,
   output logic                 mode_err,
   output logic                 access_err
);
   if (AP_BIT >= ROW_W || COL_W > AP_BIT) begin : g_chk_geom
      $error("column field must sit below the auto-precharge bit inside the address");
   end
   if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_chk_banks
      $error("bank count must be a power of two");
   end

   logic [CMD_N-1:0] strobe_d;
   logic             ap_in, is_access, err_d;
   logic [ROW_W-1:0] addr_d;
   logic [BA_W-1:0]  bank_d;
   mode_t            mode;

   assign ap_in = addr[AP_BIT];

   sdcf_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cke(cke), .all_sel(ap_in), .strobe(strobe_d)
   );

   sdcf_banks #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .strobe(strobe_d), .ba(ba),
      .ap(ap_in), .active(bank_active)
   );

   sdcf_mode #(.ADDR_W(ROW_W), .RESET_CL(3'd3)) u_mode (
      .clk(clk), .rst_n(rst_n), .load(strobe_d[S_MRS]), .value(addr),
      .mode(mode), .err(mode_err)
   );

   assign is_access = strobe_d[S_RD] || strobe_d[S_WR];
   assign err_d     = is_access && !bank_active[ba];

   always_comb begin
      addr_d = '0;
      bank_d = '0;
      if (strobe_d[S_ACT]) addr_d = addr;
      else if (is_access)  addr_d = ROW_W'(addr[COL_W-1:0]);
      if (strobe_d[S_ACT] || strobe_d[S_PRE] || is_access) bank_d = ba;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_strobe  <= '0;
         cmd_bank    <= '0;
         cmd_addr    <= '0;
         cmd_autopre <= 1'b0;
         access_err  <= 1'b0;
      end else begin
         cmd_strobe  <= strobe_d;
         cmd_bank    <= bank_d;
         cmd_addr    <= addr_d;
         cmd_autopre <= is_access && ap_in;
         access_err  <= err_d;
      end
   end

   assign mr_burst_len  = mode.burst_len;
   assign mr_burst_type = mode.burst_type;
   assign mr_cas_lat    = mode.cas_lat;
   assign mr_wr_single  = mode.wr_single;
endmodule

// File: rtl/sdcf_checker.sv
module sdcf_checker
   import sdcf_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic                 cke,
   input logic [CMD_N-1:0]     cmd_strobe,
   input logic [BA_W-1:0]      cmd_bank,
   input logic [NUM_BANKS-1:0] bank_active,
   input logic [2:0]           mr_burst_len,
   input logic                 mr_burst_type,
   input logic [2:0]           mr_cas_lat,
   input logic                 mr_wr_single,
   input logic                 mode_err,
   input logic                 access_err
);
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_strobe));

   p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_n) || !$past(cke)) |-> (cmd_strobe == '0));

   p_act_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe[S_ACT] |-> bank_active[cmd_bank]);

   p_preall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe[S_PREALL] |-> (bank_active == '0));

   p_refused_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> ($stable(mr_burst_len) && $stable(mr_burst_type)
                    && $stable(mr_cas_lat) && $stable(mr_wr_single)));

   p_refused_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> cmd_strobe[S_MRS]);

   p_cl_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mr_cas_lat == 3'd2) || (mr_cas_lat == 3'd3));

   p_access_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      access_err |-> (cmd_strobe[S_RD] || cmd_strobe[S_WR]));
endmodule

bind sdram_cmd_front sdcf_checker #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cke(cke),
   .cmd_strobe(cmd_strobe), .cmd_bank(cmd_bank), .bank_active(bank_active),
   .mr_burst_len(mr_burst_len), .mr_burst_type(mr_burst_type),
   .mr_cas_lat(mr_cas_lat), .mr_wr_single(mr_wr_single),
   .mode_err(mode_err), .access_err(access_err)
);

// File: tb/test_sdram_cmd_front.sv
module test_sdram_cmd_front;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [8:0]  cmd_strobe;
   logic [1:0]  cmd_bank;
   logic [12:0] cmd_addr;
   logic        cmd_autopre;
   logic [3:0]  bank_active;
   logic [2:0]  mr_burst_len, mr_cas_lat;
   logic        mr_burst_type, mr_wr_single, mode_err, access_err;

   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sdram_cmd_front i_sdram_cmd_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
      .cmd_strobe(cmd_strobe), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
      .cmd_autopre(cmd_autopre), .bank_active(bank_active),
      .mr_burst_len(mr_burst_len), .mr_burst_type(mr_burst_type),
      .mr_cas_lat(mr_cas_lat), .mr_wr_single(mr_wr_single),
      .mode_err(mode_err), .access_err(access_err)
   );

   typedef struct {
      logic [8:0]  strobe;
      logic [1:0]  bank;
      logic [12:0] addr;
      logic        ap;
      logic [3:0]  act;
      logic [7:0]  mode;
      logic        merr;
      logic        aerr;
      string       tag;
   } exp_t;

   exp_t q[$];
   logic [3:0] m_act = '0;
   logic [7:0] m_mode = {3'd0, 1'b0, 3'd3, 1'b0};

   function automatic logic [28:0] pack_out();
      return {cmd_strobe, cmd_bank, cmd_addr, cmd_autopre, bank_active};
   endfunction

   task automatic compare(exp_t e);
      logic [7:0] got_mode;
      logic [28:0] got, want;
      got_mode = {mr_burst_len, mr_burst_type, mr_cas_lat, mr_wr_single};
      got  = pack_out();
      want = {e.strobe, e.bank, e.addr, e.ap, e.act};
      total++;
      if (got !== want || got_mode !== e.mode || mode_err !== e.merr || access_err !== e.aerr) begin
         bad++;
         $display("FAIL %s: got out=%h mode=%h merr=%b aerr=%b exp out=%h mode=%h merr=%b aerr=%b",
                  e.tag, got, got_mode, mode_err, access_err, want, e.mode, e.merr, e.aerr);
      end
   endtask

   // driver: applies one sampled cycle and pushes the expected result
   task automatic drive(input logic c, r, k, w, ce, input logic [1:0] b,
                        input logic [12:0] a, input string tag);
      exp_t e;
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = k; we_n = w; cke = ce; ba = b; addr = a;
      e.strobe = '0; e.bank = '0; e.addr = '0; e.ap = 1'b0;
      e.merr = 1'b0; e.aerr = 1'b0; e.tag = tag;
      if (!c && ce) begin
         case ({r, k, w})
            3'b111: e.strobe[0] = 1'b1;
            3'b011: begin e.strobe[1] = 1'b1; e.bank = b; e.addr = a; m_act[b] = 1'b1; end
            3'b101, 3'b100: begin
               e.strobe[({r,k,w} == 3'b101) ? 2 : 3] = 1'b1;
               e.bank = b; e.addr = {4'd0, a[8:0]}; e.ap = a[10];
               e.aerr = !m_act[b];
               if (a[10]) m_act[b] = 1'b0;
            end
            3'b010: begin
               if (a[10]) begin e.strobe[5] = 1'b1; m_act = '0; end
               else begin e.strobe[4] = 1'b1; e.bank = b; m_act[b] = 1'b0; end
            end
            3'b001: e.strobe[6] = 1'b1;
            3'b000: begin
               e.strobe[7] = 1'b1;
               if ((a[6:4] == 3'd2 || a[6:4] == 3'd3) && a[8:7] == 2'b00)
                  m_mode = {a[2:0], a[3], a[6:4], a[9]};
               else e.merr = 1'b1;
            end
            default: e.strobe[8] = 1'b1;
         endcase
      end
      e.act = m_act; e.mode = m_mode;
      q.push_back(e);
   endtask

   // monitor: pops one expected item per clock, sampled after the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) compare(q.pop_front());
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset values
      begin
         exp_t e;
         e.strobe = '0; e.bank = '0; e.addr = '0; e.ap = 0; e.act = '0;
         e.mode = {3'd0, 1'b0, 3'd3, 1'b0}; e.merr = 0; e.aerr = 0; e.tag = "R9 reset state";
         compare(e);
      end
      rst_n = 1'b1;
      drive(0,1,1,1,1, 2'd0, 13'h0000, "R1 nop");
      drive(1,0,1,1,1, 2'd1, 13'h1ABC, "R2 deselected activate");
      drive(0,0,1,1,0, 2'd1, 13'h1ABC, "R2 cke low activate");
      drive(0,0,1,1,1, 2'd1, 13'h1ABC, "R3 activate bank1");
      drive(0,1,0,1,1, 2'd1, 13'h09F5, "R4 read bank1 column");
      drive(0,1,0,0,1, 2'd2, 13'h0033, "R8 write idle bank2");
      drive(0,0,1,1,1, 2'd2, 13'h0777, "R3 activate bank2");
      drive(0,0,1,1,1, 2'd3, 13'h1FFF, "R3 activate bank3");
      drive(0,1,0,0,1, 2'd2, 13'h1555, "R4 write bank2 auto precharge");
      drive(0,1,0,1,1, 2'd2, 13'h0001, "R8 read after auto precharge");
      drive(0,0,1,0,1, 2'd3, 13'h0000, "R5 single precharge bank3");
      drive(0,0,1,1,1, 2'd0, 13'h0100, "R3 activate bank0");
      drive(0,0,1,0,1, 2'd2, 13'h0400, "R5 precharge all");
      drive(0,0,1,0,1, 2'd0, 13'h0400, "R5 precharge all when idle");
      drive(0,0,0,1,1, 2'd0, 13'h0000, "R1 refresh");
      drive(0,1,1,0,1, 2'd0, 13'h0000, "R1 burst stop");
      drive(0,0,0,0,1, 2'd0, 13'h022B, "R6 mode load legal");
      drive(0,0,0,0,1, 2'd0, 13'h0040, "R7 mode load latency 4");
      drive(0,0,0,0,1, 2'd0, 13'h0010, "R7 mode load latency 1");
      drive(0,0,0,0,1, 2'd0, 13'h00B0, "R7 mode load test field");
      drive(1,0,0,0,1, 2'd0, 13'h0035, "R2 deselected mode load");
      drive(0,0,0,0,0, 2'd0, 13'h0035, "R2 cke low mode load");
      drive(0,0,0,0,1, 2'd0, 13'h0035, "R6 mode load latency 3");
      drive(0,1,0,1,1, 2'd1, 13'h0000, "R10 read single pulse");
      drive(1,1,1,1,1, 2'd0, 13'h0000, "R10 strobe drops after one cycle");
      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         total++; bad++;
         $display("FAIL R10: got %0d pending exp 0", q.size());
      end
      finish_run();
   end
endmodule